// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Page-Write Slave

This block is the slave side of the write path of a two-wire serial EEPROM. It oversamples the clock and data lines with the system clock, recognises start and stop conditions, checks the device-select byte, then collects two word-address bytes and any number of data bytes. Each accepted byte is acknowledged by pulling the data line low through an open-drain enable. Data bytes land in a 64-byte page latch, and every byte position carries a valid flag.

A stop condition that follows at least one accepted data byte starts a self-timed internal write cycle. During this cycle the valid bytes of the latch are copied into a behavioural memory array. While the cycle runs the block is busy and ignores the bus completely. A protection input closes the upper part of the array to writes. When it is set, a data byte aimed at that region is not acknowledged and nothing is stored. A side read port gives direct access to the array contents so they can be observed.

Top module: `eeprom_pgwr_slave`

## Requirements
- R1: A device-select byte whose bits [7:4] are 1010 and whose bit 0 is 0 is acknowledged, and bits [3:1] are don't-care. Any other device-select byte gets no acknowledge, and the bus is then ignored until the next start condition.
- R2: The acknowledge (sda_oe_o high) is given during the ninth clock of the device-select byte, of each of the two word-address bytes and of every accepted data byte. It is released on the falling edge of that ninth clock.
- R3: The first word-address byte gives address bits [MEM_AW-1:8] from its low bits, and the second gives bits [7:0]. Address bits at or above MEM_AW are ignored, so the address aliases into the array.
- R4: After each accepted data byte the low 6 address bits count up by one and wrap from 63 to 0, while the page bits do not change. For example, 12 bytes sent from location 60 fill locations 60..63 and then 0..7.
- R5: When more than 64 data bytes are sent, later bytes replace earlier ones at the same location. Only the last value sent to each location is stored.
- R6: A stop condition after at least one accepted data byte raises busy_o on the next clock. busy_o then stays high for exactly WR_CYCLES clocks, and the latched bytes are in the array once it falls.
- R7: While busy_o is high, start, stop and data on the bus have no effect, and sda_oe_o stays low.
- R8: When prot_i is 1 and the current address is at or above PROT_BASE, the data byte is not acknowledged. Nothing is written and no write cycle starts.
- R9: A start condition, at any point, discards data bytes not yet committed. A stop condition arriving in the middle of a byte commits only the complete bytes. A stop condition with no accepted data byte starts no write cycle.
- R10: After reset busy_o and sda_oe_o are low.
- R11: A write cycle changes only the locations that received data bytes. Every other location in the page keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| prot_i | input | 1 | Protects addresses at or above PROT_BASE when set |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls the data line low |
| busy_o | output | 1 | High during the internal write cycle |
| rd_addr_i | input | MEM_AW | Side read address into the array |
| rd_data_o | output | 8 | Array contents at rd_addr_i |

## Verification
The stimulus covers several cases: a write from location 60 that wraps within the page, a 70-byte burst that overwrites the start of its page, an address with high bits set, and single-byte writes beside bytes written earlier. A design with linear increment would spill into the next page, and one without per-byte valid flags would erase neighbouring bytes. The bench also sends a foreign device code, a read-direction byte, a start while busy, a stop with no data, and start and stop in the middle of a byte. A design that got these wrong would acknowledge, extend or restart the write cycle, or commit a half-received byte. Protection is checked both just below and inside the protected region. A wrong boundary shows up as a missing or extra acknowledge and as changed array contents.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_DATA
  } ctl_st_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  // Device-select check: type code in the upper nibble, write direction in bit 0.
  function automatic logic dev_match(input logic [7:0] b);
    return (b[7:4] == DEV_CODE) && (b[0] == 1'b0);
  endfunction

endpackage

// File: rtl/eepw_bus_edge.sv
module eepw_bus_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_raw,
  output logic stop_raw
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl_sync[1];
      sda_q    <= sda_sync[1];
    end
  end

  assign sda_s     = sda_sync[1];
  assign scl_rise  = scl_sync[1] & ~scl_q;
  assign scl_fall  = ~scl_sync[1] & scl_q;
  // Data edges with the clock held high in both samples.
  assign start_raw = scl_sync[1] & scl_q & sda_q & ~sda_sync[1];
  assign stop_raw  = scl_sync[1] & scl_q & ~sda_q & sda_sync[1];

endmodule

// File: rtl/eepw_byte_rx.sv
module eepw_byte_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ack_req,
  output logic       byte_done,
  output logic [7:0] byte_q,
  output logic       sda_oe
);
  logic       active;
  logic       in_ack;
  logic [3:0] bit_cnt;

  assign byte_done = active & ~in_ack & scl_fall & (bit_cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      in_ack  <= 1'b0;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
      byte_q  <= '0;
    end else if (!en) begin
      active  <= 1'b0;
      in_ack  <= 1'b0;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (ev_start) begin
      active  <= 1'b1;
      in_ack  <= 1'b0;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (ev_stop) begin
      active  <= 1'b0;
      in_ack  <= 1'b0;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (active) begin
      if (!in_ack) begin
        if (scl_rise && bit_cnt < 4'd8) begin
          byte_q  <= {byte_q[6:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (byte_done) begin
          bit_cnt <= '0;
          if (ack_req) begin
            sda_oe <= 1'b1;
            in_ack <= 1'b1;
          end else begin
            active <= 1'b0;
          end
        end
      end else if (scl_fall) begin
        sda_oe <= 1'b0;
        in_ack <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/eepw_page_latch.sv
module eepw_page_latch #(
  parameter int PAGE_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               we,
  input  logic [PAGE_AW-1:0] widx,
  input  logic [7:0]         wdata,
  input  logic [PAGE_AW-1:0] ridx,
  output logic [7:0]         rdata,
  output logic               rvalid
);
  localparam int PAGE = 1 << PAGE_AW;

  logic [7:0]      data_q [PAGE];
  logic [PAGE-1:0] valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (clr) begin
      valid_q <= '0;
    end else if (we) begin
      valid_q[widx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we && !clr) data_q[widx] <= wdata;
  end

  assign rdata  = data_q[ridx];
  assign rvalid = valid_q[ridx];

endmodule

// File: rtl/eepw_wr_engine.sv
module eepw_wr_engine #(
  parameter int MEM_AW    = 11,
  parameter int PAGE_AW   = 6,
  parameter int WR_CYCLES = 5000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit,
  input  logic [MEM_AW-PAGE_AW-1:0] page,
  output logic [PAGE_AW-1:0]        ridx,
  input  logic [7:0]                rdata,
  input  logic                      rvalid,
  output logic                      busy,
  input  logic [MEM_AW-1:0]         rd_addr,
  output logic [7:0]                rd_data
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam int PG_W  = MEM_AW - PAGE_AW;
  localparam int DEPTH = 1 << MEM_AW;

  logic [CNT_W-1:0] cnt;
  logic [PAGE_AW:0] walk;
  logic [PG_W-1:0]  pg;
  logic             walking;
  logic [7:0]       mem [DEPTH];

  assign busy    = (cnt != '0);
  assign walking = busy & ~walk[PAGE_AW];
  assign ridx    = walk[PAGE_AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      walk <= {1'b1, {PAGE_AW{1'b0}}};
      pg   <= '0;
    end else if (commit) begin
      cnt  <= CNT_W'(WR_CYCLES);
      walk <= '0;
      pg   <= page;
    end else begin
      if (busy)    cnt  <= cnt - 1'b1;
      if (walking) walk <= walk + 1'b1;
    end
  end

  // One latch position per cycle; positions never written are skipped.
  always_ff @(posedge clk) begin
    if (walking && rvalid) mem[{pg, ridx}] <= rdata;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/eeprom_pgwr_slave.sv
module eeprom_pgwr_slave
  import eepw_pkg::*;
#(
  parameter int MEM_AW    = 11,
  parameter int PAGE_AW   = 6,
  parameter int WR_CYCLES = 5000,
  parameter int PROT_BASE = 1536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              prot_i,
  output logic              sda_oe_o,
  output logic              busy_o,
  input  logic [MEM_AW-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int PG_W = MEM_AW - PAGE_AW;

  // Page-local increment: low bits roll over, page bits hold.
  function automatic logic [MEM_AW-1:0] wrap_inc(input logic [MEM_AW-1:0] a);
    logic [MEM_AW-1:0] r;
    r = a;
    r[PAGE_AW-1:0] = a[PAGE_AW-1:0] + 1'b1;
    return r;
  endfunction

  function automatic logic in_prot_blk(input logic [MEM_AW-1:0] a);
    return 32'(a) >= PROT_BASE;
  endfunction

  logic sda_s, scl_rise, scl_fall, start_raw, stop_raw;
  logic ev_start, ev_stop, ev_commit;
  logic byte_done, ack_req, data_acc, prot_hit, in_data_ph;
  logic [7:0] byte_q;
  logic [7:0] pl_rdata;
  logic       pl_rvalid;
  logic [PAGE_AW-1:0] eng_idx;

  ctl_st_t           st;
  logic [MEM_AW-1:0] waddr;
  logic              data_any;

  eepw_bus_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_raw (start_raw),
    .stop_raw  (stop_raw)
  );

  assign ev_start   = start_raw & ~busy_o;
  assign ev_stop    = stop_raw & ~busy_o;
  assign prot_hit   = prot_i & in_prot_blk(waddr);
  assign in_data_ph = (st == ST_DATA);
  assign data_acc   = byte_done & in_data_ph & ~prot_hit;
  assign ev_commit  = ev_stop & data_any;

  always_comb begin
    unique case (st)
      ST_DEV:         ack_req = dev_match(byte_q);
      ST_AHI, ST_ALO: ack_req = 1'b1;
      ST_DATA:        ack_req = ~prot_hit;
      default:        ack_req = 1'b0;
    endcase
  end

  eepw_byte_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (~busy_o),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .ack_req   (ack_req),
    .byte_done (byte_done),
    .byte_q    (byte_q),
    .sda_oe    (sda_oe_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      waddr    <= '0;
      data_any <= 1'b0;
    end else if (ev_start) begin
      st       <= ST_DEV;
      data_any <= 1'b0;
    end else if (ev_stop) begin
      st       <= ST_IDLE;
      data_any <= 1'b0;
    end else if (byte_done) begin
      unique case (st)
        ST_DEV: st <= dev_match(byte_q) ? ST_AHI : ST_IDLE;
        ST_AHI: begin
          waddr[MEM_AW-1:8] <= byte_q[MEM_AW-9:0];
          st                <= ST_ALO;
        end
        ST_ALO: begin
          waddr[7:0] <= byte_q;
          st         <= ST_DATA;
        end
        ST_DATA: begin
          if (prot_hit) begin
            st <= ST_IDLE;
          end else begin
            waddr    <= wrap_inc(waddr);
            data_any <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  eepw_page_latch #(.PAGE_AW(PAGE_AW)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (ev_start),
    .we     (data_acc),
    .widx   (waddr[PAGE_AW-1:0]),
    .wdata  (byte_q),
    .ridx   (eng_idx),
    .rdata  (pl_rdata),
    .rvalid (pl_rvalid)
  );

  eepw_wr_engine #(
    .MEM_AW    (MEM_AW),
    .PAGE_AW   (PAGE_AW),
    .WR_CYCLES (WR_CYCLES)
  ) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (ev_commit),
    .page    (waddr[MEM_AW-1:PAGE_AW]),
    .ridx    (eng_idx),
    .rdata   (pl_rdata),
    .rvalid  (pl_rvalid),
    .busy    (busy_o),
    .rd_addr (rd_addr_i),
    .rd_data (rd_data_o)
  );

  logic unused_pg;
  assign unused_pg = ^PG_W;

endmodule

// File: rtl/eepw_chk.sv
module eepw_chk #(
  parameter int PAGE_AW   = 6,
  parameter int WR_CYCLES = 5000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               sda_oe,
  input logic               ev_stop,
  input logic               byte_done,
  input logic               data_acc,
  input logic [PAGE_AW-1:0] addr_lo,
  input logic               in_data,
  input logic               prot_hit
);
  int run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= 0;
    else if (busy) run <= run + 1;
    else           run <= 0;
  end

  // R7: no acknowledge while the write cycle runs
  a_r7_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R6: write cycle length counted in the checker
  a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && run != 0) |-> (run == WR_CYCLES));

  // R6: write cycle only follows a stop
  a_r6_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ev_stop));

  // R2: acknowledge only right after a completed byte
  a_r2_ack_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(byte_done));

  // R8: protected data byte gets no acknowledge
  a_r8_prot_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && in_data && prot_hit) |=> !sda_oe);

  // R4: low address bits wrap inside the page
  a_r4_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && addr_lo == '1) |=> (addr_lo == '0));

endmodule

bind eeprom_pgwr_slave eepw_chk #(
  .PAGE_AW   (PAGE_AW),
  .WR_CYCLES (WR_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy_o),
  .sda_oe    (sda_oe_o),
  .ev_stop   (ev_stop),
  .byte_done (byte_done),
  .data_acc  (data_acc),
  .addr_lo   (waddr[PAGE_AW-1:0]),
  .in_data   (in_data_ph),
  .prot_hit  (prot_hit)
);

// File: tb/sim_eeprom_pgwr_slave.sv
`timescale 1ns/1ps
module sim_eeprom_pgwr_slave;
  localparam int MEM_AW = 11;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam int WR_CYC = 300;
  localparam int QTR    = 8;
  localparam int NVEC   = 8;

  // {word address 14, byte count 8, first data value 8, protect 1}
  localparam logic [30:0] VEC [NVEC] = '{
    {14'h0010, 8'd1,  8'h11, 1'b0},
    {14'h003C, 8'd12, 8'h20, 1'b0},
    {14'h0100, 8'd70, 8'h40, 1'b0},
    {14'h2085, 8'd3,  8'h90, 1'b0},
    {14'h0640, 8'd2,  8'h77, 1'b0},
    {14'h0640, 8'd2,  8'hA0, 1'b1},
    {14'h05F0, 8'd2,  8'hC0, 1'b1},
    {14'h003E, 8'd1,  8'h55, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, prot = 1'b0;
  logic sda_oe, busy;
  logic [MEM_AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, errs = 0;
  bit done = 0;
  logic [7:0] mdl [DEPTH];
  bit known [DEPTH];

  always #2.5 clk = ~clk;

  eeprom_pgwr_slave #(.MEM_AW(MEM_AW), .WR_CYCLES(WR_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .prot_i(prot),
    .sda_oe_o(sda_oe), .busy_o(busy), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic bstart();
    sda_m = 1'b1; tick(QTR); scl_m = 1'b1; tick(QTR);
    sda_m = 1'b0; tick(QTR); scl_m = 1'b0; tick(QTR);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tick(QTR); scl_m = 1'b1; tick(QTR); sda_m = 1'b1;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(QTR); scl_m = 1'b1; tick(2 * QTR); scl_m = 1'b0; tick(QTR);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(QTR); scl_m = 1'b1; tick(QTR);
    ack = !sda_line;
    tick(QTR); scl_m = 1'b0; tick(QTR);
  endtask

  // Counts busy clocks after a stop; 0 when no write cycle starts.
  task automatic wait_write(output int hi);
    hi = 0;
    for (int k = 0; k < WR_CYC + 200; k++) begin
      tick(1);
      if (busy) hi++;
      else if (hi != 0 || k > 40) break;
    end
    tick(QTR);
  endtask

  task automatic header(input logic [13:0] a, output int nack);
    bit ack;
    nack = 0;
    bstart();
    send_byte(8'hA0, ack); nack += int'(ack);
    send_byte({2'b00, a[13:8]}, ack); nack += int'(ack);
    send_byte(a[7:0], ack); nack += int'(ack);
  endtask

  function automatic int loc(input logic [13:0] a, input int i);
    logic [MEM_AW-1:0] m;
    m = a[MEM_AW-1:0];
    return int'({m[MEM_AW-1:6], 6'(m[5:0] + 6'(i))});
  endfunction

  task automatic model_wr(input logic [13:0] a, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      mdl[loc(a, i)] = seed + 8'(i);
      known[loc(a, i)] = 1'b1;
    end
  endtask

  task automatic check_mem(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      if (known[a]) begin
        rd_addr = MEM_AW'(a); #1;
        chk(rd_data === mdl[a], req, $sformatf("mem[%0h]", a), int'(rd_data), int'(mdl[a]));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int hdr, dacks, hi;
    bit ack;
    for (int a = 0; a < DEPTH; a++) known[a] = 1'b0;
    tick(5);
    chk(busy === 1'b0, "R10", "busy in reset", int'(busy), 0);
    chk(sda_oe === 1'b0, "R10", "sda_oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    tick(5);
    chk(busy === 1'b0 && sda_oe === 1'b0, "R10", "idle after reset", int'({busy, sda_oe}), 0);

    // Vector table: R1 R2 R3 R4 R5 R6 R8 R11
    for (int v = 0; v < NVEC; v++) begin
      logic [13:0] a;
      int n;
      logic [7:0] seed;
      bit pexp;
      a = VEC[v][30:17]; n = int'(VEC[v][16:9]); seed = VEC[v][8:1];
      prot = VEC[v][0];
      pexp = prot && (int'(a[MEM_AW-1:0]) >= 1536);
      header(a, hdr);
      dacks = 0;
      for (int i = 0; i < n; i++) begin
        send_byte(seed + 8'(i), ack);
        if (ack) dacks++; else break;
      end
      bstop();
      wait_write(hi);
      chk(hdr == 3, "R2", $sformatf("vec%0d header acks", v), hdr, 3);
      chk(dacks == (pexp ? 0 : n), "R8", $sformatf("vec%0d data acks", v), dacks, pexp ? 0 : n);
      chk(hi == (pexp ? 0 : WR_CYC), "R6", $sformatf("vec%0d busy clocks", v), hi, pexp ? 0 : WR_CYC);
      if (!pexp) model_wr(a, n, seed);
      check_mem("R4/R5/R3/R11");
      prot = 1'b0;
    end

    // R1: foreign device code, read direction, don't-care select bits
    bstart(); send_byte(8'hB0, ack); bstop(); wait_write(hi);
    chk(!ack, "R1", "foreign code ack", int'(ack), 0);
    chk(hi == 0, "R1", "foreign code busy", hi, 0);
    bstart(); send_byte(8'hA1, ack); bstop(); wait_write(hi);
    chk(!ack, "R1", "read bit ack", int'(ack), 0);
    bstart(); send_byte(8'hAE, ack); bstop(); wait_write(hi);
    chk(ack, "R1", "select bits ignored", int'(ack), 1);

    // R7: bus traffic during the write cycle is ignored
    header(14'h0300, hdr); send_byte(8'h99, ack); bstop();
    model_wr(14'h0300, 1, 8'h99);
    tick(20);
    chk(busy === 1'b1, "R6", "busy after stop", int'(busy), 1);
    bstart(); send_byte(8'hA0, ack);
    chk(!ack, "R7", "ack while busy", int'(ack), 0);
    bstop();
    for (int k = 0; k < WR_CYC && busy; k++) tick(1);
    tick(QTR);
    chk(busy === 1'b0, "R7", "busy not extended", int'(busy), 0);
    check_mem("R7");

    // R9: stop with no data
    header(14'h0200, hdr); bstop(); wait_write(hi);
    chk(hi == 0, "R9", "stop without data", hi, 0);

    // R9: stop in the middle of a byte commits only complete bytes
    header(14'h0200, hdr); send_byte(8'h30, ack); send_byte(8'h31, ack); bstop(); wait_write(hi);
    model_wr(14'h0200, 2, 8'h30);
    header(14'h0200, hdr); send_byte(8'h5A, ack); send_bits(8'hFF, 4); bstop(); wait_write(hi);
    model_wr(14'h0200, 1, 8'h5A);
    chk(hi == WR_CYC, "R9", "mid-byte stop commits", hi, WR_CYC);
    check_mem("R9");

    // R9: start in the middle of a byte discards latched data
    header(14'h0200, hdr); send_byte(8'h66, ack); send_bits(8'h00, 3);
    bstart(); bstop(); wait_write(hi);
    chk(hi == 0, "R9", "mid-byte start aborts", hi, 0);
    check_mem("R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule